// File: doc/BRIEF.md
# Three-Phase Rotation Order Checker

This block watches the rising (negative-to-positive) zero crossings of three phase voltages and checks that they arrive in the rotation order A, B, C, A, B, C and so on. Each incoming crossing is compared with the phase that should follow the one before it. Any crossing that is not that phase raises a sticky error status bit. An optional active-low interrupt follows the status bit when the mask input enables it. Software clears the status bit with a write-one-to-clear pulse.

Another unit produces the crossing strobes, one single-cycle pulse per phase. A 2-bit wiring-mode input turns the checker on only for the three-voltage-sensor, four-wire arrangement, which is code 00. For any other code the checker ignores crossings and forgets the phase it last saw. This block does no crossing detection, filtering or voltage rerouting of its own.

Top module: `zxseq_detect`

## Requirements
- R1: After synchronous reset, `seq_err` is 0 and `irq_n` is 1.
- R2: When crossings arrive in the order A, B, C repeating, `seq_err` stays 0. Strobe bit 0 is phase A, bit 1 is phase B and bit 2 is phase C.
- R3: A crossing that is not the successor of the last phase seen (A to B, B to C, C to A) sets `seq_err` on the clock edge that samples the strobe, so it is visible in the following cycle.
- R4: The first crossing after reset, or after the checker is re-enabled, never raises an error, whatever its phase.
- R5: A second crossing from the same phase with no other phase between the two is an error.
- R6: Strobes that arrive in the same cycle are handled as if they came in the order A, then B, then C. Each one is checked against the one before it, and the last one becomes the remembered phase.
- R7: `irq_n` is 0 exactly when `seq_err` is 1 and `err_mask` is 1. With the mask at 0 the status bit still sets but `irq_n` stays 1.
- R8: A cycle with `err_clr` high clears `seq_err` and releases `irq_n`. If a new error is detected in that same cycle, the error wins and `seq_err` stays 1.
- R9: When `wire_cfg` is not 00, crossings never set `seq_err`, and the remembered phase is discarded.
- R10: Once set, `seq_err` stays 1 through any later crossings until it is cleared.
- R11: Under a reversed rotation, clearing the status bit and then applying the next reversed crossing sets `seq_err` again. Every offending crossing raises an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zx_rise | input | 3 | Rising zero-crossing strobes, bit 0 = A, bit 1 = B, bit 2 = C |
| wire_cfg | input | 2 | Wiring mode; 00 enables the checker |
| err_mask | input | 1 | Lets the error drive the interrupt |
| err_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| seq_err | output | 1 | Sticky rotation-order error status |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest situations to reach are a cycle with more than one strobe, where the fixed A-B-C resolution decides both the error and the phase that is remembered, and a clear that lands in the same cycle as a fresh error. The directed part of the stimulus builds both on purpose, starting from a known remembered phase. The random part sends mostly in-order crossings, with occasional repeats, swapped phases, multi-phase cycles, clears, mask changes and mode changes. A bench model tracks the remembered phase and the status bit from the requirements, and every cycle is compared against it.

// File: rtl/zxseq_pkg.sv
package zxseq_pkg;

    localparam int NPH = 3;
    localparam int CFG_W = 2;
    localparam logic [CFG_W-1:0] WIRE_3V4W = 2'b00;

    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2
    } phase_e;

    typedef struct packed {
        logic   valid;
        phase_e ph;
    } hist_t;

    localparam hist_t HIST_EMPTY = '{valid: 1'b0, ph: PH_A};

    function automatic phase_e succ_of(input phase_e p);
        case (p)
            PH_A:    succ_of = PH_B;
            PH_B:    succ_of = PH_C;
            default: succ_of = PH_A;
        endcase
    endfunction

endpackage

// File: rtl/zxseq_chain.sv
module zxseq_chain
    import zxseq_pkg::*;
(
    input  hist_t            hist_in,
    input  logic [NPH-1:0]   zx,
    output hist_t            hist_out,
    output logic             bad
);
    hist_t h_s [NPH+1];
    logic  b_s [NPH+1];

    assign h_s[0] = hist_in;
    assign b_s[0] = 1'b0;

    for (genvar i = 0; i < NPH; i++) begin : g_stage
        localparam phase_e THIS_PH = phase_e'(2'(i));
        logic mismatch;
        assign mismatch = h_s[i].valid && (succ_of(h_s[i].ph) != THIS_PH);
        assign h_s[i+1] = zx[i] ? '{valid: 1'b1, ph: THIS_PH} : h_s[i];
        assign b_s[i+1] = b_s[i] | (zx[i] & mismatch);
    end

    assign hist_out = h_s[NPH];
    assign bad      = b_s[NPH];
endmodule

// File: rtl/zxseq_track.sv
module zxseq_track
    import zxseq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [NPH-1:0] zx,
    output logic           err_pulse
);
    hist_t hist_q, hist_d;
    logic  bad;

    zxseq_chain u_chain (
        .hist_in (hist_q),
        .zx      (zx),
        .hist_out(hist_d),
        .bad     (bad)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) hist_q <= HIST_EMPTY;
        else            hist_q <= hist_d;
    end

    assign err_pulse = en & bad;

    // R4: with no history, a single crossing cannot be an error
    p_first_free_r4: assert property (@(posedge clk) disable iff (rst)
        (!hist_q.valid && $countones(zx) == 1) |-> !err_pulse);

    // R9: disabling drops the remembered phase
    p_forget_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> !hist_q.valid);

    // R5: same phase twice in a row flags
    p_repeat_r5: assert property (@(posedge clk) disable iff (rst)
        (en && hist_q.valid && $countones(zx) == 1 && zx[hist_q.ph]) |-> err_pulse);
endmodule

// File: rtl/zxseq_status.sv
module zxseq_status (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic mask_i,
    output logic stat_o,
    output logic irq_n_o
);
    logic stat_q;

    always_ff @(posedge clk) begin
        if (rst)        stat_q <= 1'b0;
        else if (set_i) stat_q <= 1'b1;
        else if (clr_i) stat_q <= 1'b0;
    end

    assign stat_o  = stat_q;
    assign irq_n_o = !(stat_q && mask_i);

    p_set_r3: assert property (@(posedge clk) disable iff (rst)
        set_i |=> stat_q);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !stat_q);

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (stat_q && !clr_i) |=> stat_q);
endmodule

// File: rtl/zxseq_detect.sv
module zxseq_detect
    import zxseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPH-1:0]   zx_rise,
    input  logic [CFG_W-1:0] wire_cfg,
    input  logic             err_mask,
    input  logic             err_clr,
    output logic             seq_err,
    output logic             irq_n
);
    logic en;
    logic err_pulse;

    assign en = (wire_cfg == WIRE_3V4W);

    zxseq_track u_track (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .zx       (zx_rise),
        .err_pulse(err_pulse)
    );

    zxseq_status u_status (
        .clk    (clk),
        .rst    (rst),
        .set_i  (err_pulse),
        .clr_i  (err_clr),
        .mask_i (err_mask),
        .stat_o (seq_err),
        .irq_n_o(irq_n)
    );

    p_irq_low_r7: assert property (@(posedge clk) disable iff (rst)
        (seq_err && err_mask) |-> !irq_n);

    p_irq_high_r7: assert property (@(posedge clk) disable iff (rst)
        (!seq_err || !err_mask) |-> irq_n);

    p_off_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!en && !seq_err) |=> !seq_err);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!seq_err && irq_n));
endmodule

// File: tb/sim_zxseq_detect.sv
module sim_zxseq_detect;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] zx_rise = '0;
    logic [1:0] wire_cfg = '0;
    logic       err_mask = 1'b0;
    logic       err_clr = 1'b0;
    logic       seq_err;
    logic       irq_n;

    int n_tests = 0;
    int n_fail  = 0;

    // bench model
    bit m_have = 0;
    int m_last = 0;
    bit m_stat = 0;

    always #4 clk = ~clk;

    zxseq_detect u0 (
        .clk(clk), .rst(rst), .zx_rise(zx_rise), .wire_cfg(wire_cfg),
        .err_mask(err_mask), .err_clr(err_clr), .seq_err(seq_err), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic void model_step(input logic [2:0] z, input logic [1:0] c,
                                       input logic cl, input logic r);
        bit bad = 0;
        if (r) begin
            m_have = 0; m_stat = 0; return;
        end
        if (c != 2'b00) begin
            m_have = 0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (z[i]) begin
                    if (m_have && ((m_last + 1) % 3) != i) bad = 1;
                    m_last = i;
                    m_have = 1;
                end
            end
        end
        if (bad) m_stat = 1;
        else if (cl) m_stat = 0;
    endfunction

    // one cycle: drive at negedge, check model shortly after posedge
    task automatic cyc(input logic [2:0] z, input logic [1:0] c, input logic m, input logic cl);
        @(negedge clk);
        zx_rise = z; wire_cfg = c; err_mask = m; err_clr = cl;
        @(posedge clk);
        model_step(z, c, cl, rst);
        #2;
        chk("R3/R7 model seq_err", seq_err, m_stat);
        chk("R7 model irq_n", irq_n, !(m_stat && m));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; zx_rise = '0; err_clr = 0;
        @(posedge clk);
        model_step('0, wire_cfg, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #1000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        logic [2:0] z;
        int unused;
        unused = $urandom(32'd9173);
        do_reset();
        #1;
        chk("R1 reset seq_err", seq_err, 1'b0);
        chk("R1 reset irq_n", irq_n, 1'b1);

        // R2 in-order rotation
        for (int k = 0; k < 6; k++) begin
            cyc(3'b001 << (k % 3), 2'b00, 1'b1, 1'b0);
            chk("R2 in order", seq_err, 1'b0);
        end

        // R4 first crossing after reset may be any phase
        do_reset();
        cyc(3'b100, 2'b00, 1'b1, 1'b0);
        chk("R4 first C", seq_err, 1'b0);
        cyc(3'b001, 2'b00, 1'b1, 1'b0);
        chk("R2 C then A", seq_err, 1'b0);

        // R3 A then C
        cyc(3'b100, 2'b00, 1'b1, 1'b0);
        chk("R3 A->C", seq_err, 1'b1);
        chk("R7 irq low", irq_n, 1'b0);
        // R10 sticky on correct crossing (C->A)
        cyc(3'b001, 2'b00, 1'b1, 1'b0);
        chk("R10 sticky", seq_err, 1'b1);
        // R8 clear
        cyc(3'b000, 2'b00, 1'b1, 1'b1);
        chk("R8 cleared", seq_err, 1'b0);
        chk("R8 irq released", irq_n, 1'b1);

        // R11 reversed rotation: last A, then C, B
        cyc(3'b100, 2'b00, 1'b1, 1'b0);
        chk("R11 C after A", seq_err, 1'b1);
        cyc(3'b000, 2'b00, 1'b1, 1'b1);
        cyc(3'b010, 2'b00, 1'b1, 1'b0);
        chk("R11 B after C", seq_err, 1'b1);
        cyc(3'b000, 2'b00, 1'b1, 1'b1);

        // R5 repeat B
        cyc(3'b010, 2'b00, 1'b1, 1'b0);
        chk("R5 repeat B", seq_err, 1'b1);
        cyc(3'b000, 2'b00, 1'b1, 1'b1);

        // R6 simultaneous A+C after B: B->A bad anyway; use C first
        cyc(3'b100, 2'b00, 1'b1, 1'b0);
        chk("R2 B->C", seq_err, 1'b0);
        cyc(3'b101, 2'b00, 1'b1, 1'b0);
        chk("R6 A+C same cycle", seq_err, 1'b1);
        cyc(3'b000, 2'b00, 1'b1, 1'b1);
        cyc(3'b011, 2'b00, 1'b1, 1'b0);
        chk("R6 A+B after C", seq_err, 1'b0);
        cyc(3'b100, 2'b00, 1'b1, 1'b0);
        chk("R6 remembered B", seq_err, 1'b0);

        // R7 masked error
        cyc(3'b100, 2'b00, 1'b0, 1'b0);
        chk("R7 masked status set", seq_err, 1'b1);
        chk("R7 masked irq high", irq_n, 1'b1);
        // R8 set wins over clear (last C, B is bad)
        cyc(3'b010, 2'b00, 1'b1, 1'b1);
        chk("R8 set beats clear", seq_err, 1'b1);
        cyc(3'b000, 2'b00, 1'b1, 1'b1);

        // R9 disabled mode
        cyc(3'b001, 2'b01, 1'b1, 1'b0);
        cyc(3'b001, 2'b10, 1'b1, 1'b0);
        cyc(3'b100, 2'b11, 1'b1, 1'b0);
        chk("R9 disabled ignores", seq_err, 1'b0);
        cyc(3'b010, 2'b00, 1'b1, 1'b0);
        chk("R9 history dropped", seq_err, 1'b0);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            int r = $urandom_range(0, 99);
            if (r < 70)       z = 3'b001 << ((m_last + 1) % 3);
            else if (r < 80)  z = 3'b000;
            else              z = 3'($urandom_range(0, 7));
            cyc(z,
                ($urandom_range(0, 29) == 0) ? 2'($urandom_range(1, 3)) : 2'b00,
                1'($urandom_range(0, 3) != 0),
                1'($urandom_range(0, 9) == 0));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule